// File: doc/BRIEF.md
# SPI Flash Identification and Status Responder

This block is the command layer of the slave side of a serial NOR flash, limited to identification and status traffic. A byte-level SPI slave shifter sits in front of it. The shifter hands over each received byte for one clock with `rx_valid`. The responder presents the byte that the shifter should send on MISO in the next byte slot on `tx_byte`. Chip select (`cs_n`, active low) is sampled on the system clock. While it is high, every frame is aborted and the block returns to waiting for an opcode.

The block provides several services:
- It answers a three-byte identification read.
- It answers a legacy signature read that returns the device code after three dummy bytes.
- It answers a two-ID read whose reply order is chosen by a selector byte.
- It serves the status byte in every slot of a status read.
- It keeps a write-enable flag.
- It commits status writes at the end of the frame.

Bit 0 of the status byte reflects the `busy` input from the array engine. The array itself, erase and program timing, and the serial shifting are outside the block.

Control is a single state machine, `resp_cmd_fsm`:
- `S_IDLE` waits for an opcode. On an opcode byte it moves to one of the following:
  - `S_JEDEC` (0x9F)
  - `S_STRD` (0x05)
  - `S_STWR` (0x01)
  - `S_SIG` (0xAB)
  - `S_REMS` (0x90)
  - `S_DRAIN` for write enable (0x06), write disable (0x04) and every other opcode.
- No transition leaves a command state except back to `S_IDLE`, which every state takes whenever `cs_n` is sampled high.
- The move from `S_STWR` to `S_IDLE` is also the commit point of a status write.

Top module: `flash_id_status_responder`

## Requirements
- R1: After reset and whenever `cs_n` is high, `tx_byte` is 0xFF. After reset the stored status bits and the write-enable flag are 0.
- R2: After opcode 0x9F, byte slots 2, 3 and 4 of the frame carry the manufacturer code, the memory type and the device code, in that order. Later slots carry 0xFF.
- R3: After opcode 0x05, every later slot of the frame, however many there are, carries the status byte. Its bit 0 is `busy`, bit 1 is the write-enable flag, bits 5:2 are the block-protect field, bit 6 is the continuous-program flag and bit 7 is the write-lock flag.
- R4: Opcode 0x06 sets the write-enable flag and opcode 0x04 clears it. Both take effect as soon as the opcode byte is received.
- R5: After opcode 0xAB, slots 2 to 4 are dummies carrying 0xFF, slot 5 carries the device code and later slots carry 0xFF.
- R6: After opcode 0x90, slots 2 and 3 are dummies and slot 4 is a selector. With selector bit 0 clear, slots 5 and 6 carry the manufacturer code then the device code. With it set, they carry the device code then the manufacturer code. All other slots carry 0xFF.
- R7: After opcode 0x01, bits 7:2 of the first data byte replace the stored status bits when `cs_n` next rises, provided the write-enable flag is set; the commit then clears the flag. A second data byte and any further bytes are ignored.
- R8: A status write made while the write-enable flag is clear leaves the status byte unchanged.
- R9: While status bit 7 is set, status writes leave the status byte unchanged and do not clear the write-enable flag.
- R10: Any opcode other than the seven listed gets 0xFF in every slot and changes neither the status bits nor the write-enable flag.
- R11: A status-write frame that ends before any data byte arrives commits nothing and leaves the write-enable flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from the bus, active low, synchronous to `clk` |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a completed received byte |
| rx_byte | input | 8 | Byte received on MOSI |
| busy | input | 1 | Write-in-progress flag from the array engine |
| tx_byte | output | 8 | Byte to shift out on MISO in the next slot |

## Verification
The assertions assume that `rx_valid` is seen only while `cs_n` is low. They also assume that at least one clock separates two strobes, so each byte is counted once and `tx_byte` has settled before the shifter loads it. The stimulus holds `rx_valid` for a single cycle followed by an idle cycle. It raises `cs_n` only between bytes and keeps it high for two cycles before a new frame. The sweeps cover every opcode value, every selector value and every writable status pattern, with the lock bit tested from a fresh reset.

// File: rtl/flash_resp_pkg.sv
package flash_resp_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_JEDEC,
        S_STRD,
        S_STWR,
        S_SIG,
        S_REMS,
        S_DRAIN
    } resp_state_t;

    localparam logic [7:0] OP_JEDEC   = 8'h9F;
    localparam logic [7:0] OP_STRD    = 8'h05;
    localparam logic [7:0] OP_STWR    = 8'h01;
    localparam logic [7:0] OP_WREN    = 8'h06;
    localparam logic [7:0] OP_WRDIS   = 8'h04;
    localparam logic [7:0] OP_SIG     = 8'hAB;
    localparam logic [7:0] OP_REMS    = 8'h90;
    localparam logic [7:0] REPLY_NONE = 8'hFF;

endpackage

// File: rtl/resp_cmd_fsm.sv
module resp_cmd_fsm
    import flash_resp_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output resp_state_t       state_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              dev_first_o,
    output logic [7:0]        wr_data_o,
    output logic              set_wel_o,
    output logic              clr_wel_o,
    output logic              commit_o
);
    localparam logic [SLOT_W-1:0] SLOT_MAX = {SLOT_W{1'b1}};
    localparam logic [SLOT_W-1:0] SLOT_SEL = SLOT_W'(3);
    localparam logic [SLOT_W-1:0] SLOT_WD  = SLOT_W'(1);

    resp_state_t       state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic              dev_first_q;
    logic [7:0]        wr_data_q;
    logic              wr_have_q;
    logic              take;

    assign take = rx_valid && !cs_n;

    // next state
    always_comb begin
        state_d = state_q;
        if (cs_n) begin
            state_d = S_IDLE;
        end else if (rx_valid && state_q == S_IDLE) begin
            unique case (rx_byte)
                OP_JEDEC: state_d = S_JEDEC;
                OP_STRD:  state_d = S_STRD;
                OP_STWR:  state_d = S_STWR;
                OP_SIG:   state_d = S_SIG;
                OP_REMS:  state_d = S_REMS;
                default:  state_d = S_DRAIN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // per-frame context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q      <= '0;
            dev_first_q <= 1'b0;
            wr_data_q   <= '0;
            wr_have_q   <= 1'b0;
        end else if (cs_n) begin
            slot_q      <= '0;
            dev_first_q <= 1'b0;
            wr_have_q   <= 1'b0;
        end else if (rx_valid) begin
            if (slot_q != SLOT_MAX) slot_q <= slot_q + 1'b1;
            if (state_q == S_REMS && slot_q == SLOT_SEL) dev_first_q <= rx_byte[0];
            if (state_q == S_STWR && slot_q == SLOT_WD) begin
                wr_data_q <= rx_byte;
                wr_have_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        set_wel_o   = take && state_q == S_IDLE && rx_byte == OP_WREN;
        clr_wel_o   = take && state_q == S_IDLE && rx_byte == OP_WRDIS;
        commit_o    = cs_n && state_q == S_STWR && wr_have_q;
        state_o     = state_q;
        slot_o      = slot_q;
        dev_first_o = dev_first_q;
        wr_data_o   = wr_data_q;
    end

endmodule

// File: rtl/resp_status_reg.sv
module resp_status_reg #(
    parameter int STORE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               busy,
    input  logic               set_wel,
    input  logic               clr_wel,
    input  logic               commit,
    input  logic [7:0]         wr_data,
    output logic [7:0]         status_o,
    output logic               wel_o,
    output logic [STORE_W-1:0] prot_o
);
    logic [STORE_W-1:0] prot_q;
    logic               wel_q;
    logic               locked;
    logic               accept;

    assign locked = prot_q[STORE_W-1];
    assign accept = commit && wel_q && !locked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q <= '0;
            wel_q  <= 1'b0;
        end else if (accept) begin
            prot_q <= wr_data[7:8-STORE_W];
            wel_q  <= 1'b0;
        end else if (set_wel) begin
            wel_q  <= 1'b1;
        end else if (clr_wel) begin
            wel_q  <= 1'b0;
        end
    end

    assign status_o = {prot_q, wel_q, busy};
    assign wel_o    = wel_q;
    assign prot_o   = prot_q;

endmodule

// File: rtl/resp_reply_mux.sv
module resp_reply_mux
    import flash_resp_pkg::*;
#(
    parameter logic [7:0] MFR_ID   = 8'h5A,
    parameter logic [7:0] MEM_TYPE = 8'h40,
    parameter logic [7:0] DEV_ID   = 8'h17,
    parameter int         SLOT_W   = 3
) (
    input  logic              cs_n,
    input  resp_state_t       state,
    input  logic [SLOT_W-1:0] slot,
    input  logic              dev_first,
    input  logic [7:0]        status,
    output logic [7:0]        tx_byte
);
    always_comb begin
        tx_byte = REPLY_NONE;
        if (!cs_n) begin
            case (state)
                S_JEDEC: begin
                    if      (slot == SLOT_W'(1)) tx_byte = MFR_ID;
                    else if (slot == SLOT_W'(2)) tx_byte = MEM_TYPE;
                    else if (slot == SLOT_W'(3)) tx_byte = DEV_ID;
                end
                S_STRD: tx_byte = status;
                S_SIG: begin
                    if (slot == SLOT_W'(4)) tx_byte = DEV_ID;
                end
                S_REMS: begin
                    if      (slot == SLOT_W'(4)) tx_byte = dev_first ? DEV_ID : MFR_ID;
                    else if (slot == SLOT_W'(5)) tx_byte = dev_first ? MFR_ID : DEV_ID;
                end
                default: tx_byte = REPLY_NONE;
            endcase
        end
    end

endmodule

// File: rtl/flash_id_status_responder.sv
module flash_id_status_responder
    import flash_resp_pkg::*;
#(
    parameter logic [7:0] MFR_ID   = 8'h5A,
    parameter logic [7:0] MEM_TYPE = 8'h40,
    parameter logic [7:0] DEV_ID   = 8'h17,
    parameter int         SLOT_W   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       busy,
    output logic [7:0] tx_byte
);
    localparam int STORE_W = 6;

    resp_state_t        st;
    logic [SLOT_W-1:0]  slot;
    logic               dev_first;
    logic [7:0]         wr_data;
    logic               set_wel, clr_wel, commit;
    logic [7:0]         status;
    logic               wel;
    logic [STORE_W-1:0] prot;

    resp_cmd_fsm #(.SLOT_W(SLOT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .state_o(st), .slot_o(slot), .dev_first_o(dev_first), .wr_data_o(wr_data),
        .set_wel_o(set_wel), .clr_wel_o(clr_wel), .commit_o(commit)
    );

    resp_status_reg #(.STORE_W(STORE_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .busy(busy), .set_wel(set_wel), .clr_wel(clr_wel),
        .commit(commit), .wr_data(wr_data), .status_o(status), .wel_o(wel), .prot_o(prot)
    );

    resp_reply_mux #(.MFR_ID(MFR_ID), .MEM_TYPE(MEM_TYPE), .DEV_ID(DEV_ID), .SLOT_W(SLOT_W)) u_mux (
        .cs_n(cs_n), .state(st), .slot(slot), .dev_first(dev_first),
        .status(status), .tx_byte(tx_byte)
    );

endmodule

// File: rtl/flash_resp_checker.sv
module flash_resp_checker #(
    parameter int SLOT_W  = 3,
    parameter int STORE_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_n,
    input logic               rx_valid,
    input logic [7:0]         rx_byte,
    input logic [7:0]         tx_byte,
    input logic               wel,
    input logic [STORE_W-1:0] prot,
    input logic [SLOT_W-1:0]  slot
);
    p_idle_reply_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> tx_byte == 8'hFF);

    p_slot_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> slot == '0);

    p_wel_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rx_valid && slot == '0 && rx_byte == 8'h06) |=> wel);

    p_wel_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rx_valid && slot == '0 && rx_byte == 8'h04) |=> !wel);

    p_wel_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(!cs_n && rx_valid && rx_byte == 8'h06));

    p_commit_at_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot) |-> $past(cs_n));

    p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prot[STORE_W-1] |=> $stable(prot));

endmodule

bind flash_id_status_responder flash_resp_checker #(.SLOT_W(SLOT_W), .STORE_W(STORE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_byte(tx_byte), .wel(wel), .prot(prot), .slot(slot)
);

// File: tb/flash_id_status_responder_test.sv
`timescale 1ns/1ps
module flash_id_status_responder_test;
    localparam logic [7:0] MFR = 8'h5A;
    localparam logic [7:0] TYP = 8'h40;
    localparam logic [7:0] DEV = 8'h17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       busy = 1'b0;
    logic [7:0] tx_byte;

    int checks = 0;
    int errors = 0;
    logic [7:0] mo [0:9];
    logic [7:0] mi [0:9];
    logic [5:0] e_prot;
    logic       e_wel;
    logic [7:0] s;

    flash_id_status_responder #(.MFR_ID(MFR), .MEM_TYPE(TYP), .DEV_ID(DEV)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .busy(busy), .tx_byte(tx_byte)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cs_n = 1'b1; rx_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        e_prot = '0; e_wel = 1'b0;
        @(negedge clk);
    endtask

    task automatic frame(input int n);
        @(negedge clk);
        cs_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mi[i] = tx_byte;
            rx_valid = 1'b1; rx_byte = mo[i];
            @(negedge clk);
            rx_valid = 1'b0;
        end
        cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] exp_stat();
        return {e_prot, e_wel, busy};
    endfunction

    task automatic read_status(input string req, input int n);
        mo[0] = 8'h05;
        for (int i = 1; i < n; i++) mo[i] = 8'(i * 37);
        frame(n);
        chk(req, mi[0], 8'hFF);
        for (int i = 1; i < n; i++) chk(req, mi[i], exp_stat());
    endtask

    task automatic one_op(input logic [7:0] op);
        mo[0] = op;
        frame(1);
    endtask

    task automatic stat_write(input logic [7:0] d1, input int n);
        mo[0] = 8'h01; mo[1] = d1; mo[2] = ~d1;
        frame(n);
        if (n >= 2 && e_wel && !e_prot[5]) begin
            e_prot = d1[7:2];
            e_wel  = 1'b0;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual 00 expected 01");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state, tx idle
        chk("R1 idle tx", tx_byte, 8'hFF);
        read_status("R1 R3 status after reset", 4);

        // R3: busy flag and repeated slots beyond slot counter range
        busy = 1'b1;
        read_status("R3 busy bit", 10);
        busy = 1'b0;
        read_status("R3 repeated status", 10);

        // R2: identification read
        mo[0] = 8'h9F; for (int i = 1; i < 7; i++) mo[i] = 8'h00;
        frame(7);
        chk("R2 opcode slot", mi[0], 8'hFF);
        chk("R2 manufacturer", mi[1], MFR);
        chk("R2 memory type", mi[2], TYP);
        chk("R2 device", mi[3], DEV);
        for (int i = 4; i < 7; i++) chk("R2 trailing", mi[i], 8'hFF);

        // R5: legacy signature
        mo[0] = 8'hAB; for (int i = 1; i < 8; i++) mo[i] = 8'h3C;
        frame(8);
        for (int i = 0; i < 8; i++) chk("R5 signature slot", mi[i], (i == 4) ? DEV : 8'hFF);

        // R6: two-ID read, every selector value
        for (int sel = 0; sel < 256; sel++) begin
            mo[0] = 8'h90; mo[1] = 8'h00; mo[2] = 8'h00; mo[3] = 8'(sel);
            mo[4] = 8'h00; mo[5] = 8'h00; mo[6] = 8'h00;
            frame(7);
            for (int i = 0; i < 4; i++) chk("R6 dummy slot", mi[i], 8'hFF);
            chk("R6 first id", mi[4], sel[0] ? DEV : MFR);
            chk("R6 second id", mi[5], sel[0] ? MFR : DEV);
            chk("R6 trailing", mi[6], 8'hFF);
        end

        // R4: write enable / disable
        one_op(8'h06); e_wel = 1'b1;
        read_status("R4 enable sets flag", 3);
        one_op(8'h04); e_wel = 1'b0;
        read_status("R4 disable clears flag", 3);

        // R8: write without enable
        stat_write(8'hFC, 2);
        read_status("R8 write without enable", 3);

        // R10: every unsupported opcode, with the flag and stored bits set
        one_op(8'h06); e_wel = 1'b1;
        stat_write(8'h54, 2);
        one_op(8'h06); e_wel = 1'b1;
        for (int op = 0; op < 256; op++) begin
            if (op != 8'h9F && op != 8'h05 && op != 8'h01 && op != 8'h06 &&
                op != 8'h04 && op != 8'hAB && op != 8'h90) begin
                mo[0] = 8'(op); mo[1] = 8'h05; mo[2] = 8'h00; mo[3] = 8'h01;
                frame(4);
                for (int i = 0; i < 4; i++) chk("R10 unsupported reply", mi[i], 8'hFF);
            end
        end
        read_status("R10 no side effect", 3);

        // R11: status write aborted before data
        stat_write(8'h00, 1);
        read_status("R11 aborted write", 3);

        // R7 / R9: every writable pattern from a fresh reset
        for (int v = 0; v < 64; v++) begin
            do_reset();
            one_op(8'h06); e_wel = 1'b1;
            stat_write({6'(v), 2'(v)}, 3);
            read_status("R7 committed pattern", 3);
            if (v[5]) begin
                one_op(8'h06); e_wel = 1'b1;
                stat_write(8'h00, 2);
                read_status("R9 locked write", 3);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule